// File: doc/BRIEF.md
# Parallel ADC Host Interface Controller

This block is the host-side sequencer for a 16-bit successive-approximation converter that has a parallel data bus. The converter is steered by an active-low chip select, a read/convert level and a reset line, and it signals the end of each conversion with an active-low flag. A single start strobe makes the controller run one full cycle. In that cycle it issues three chip-select pulses. The first opens acquisition. The second starts the conversion and also tells the converter which power state to enter afterwards. The third moves the result onto the bus, where the controller captures it.

Every analog timing limit is a parameter counted in system-clock cycles. These limits are read/convert setup and hold, chip-select low and high widths, the acquisition time, the data-valid delay and the bus release gap. A long reference wake-up wait is added only when the converter was left in shutdown, or has just been reset. The captured code is handed to the host with a one-cycle valid strobe. When the parameter for bipolar coding is set, the code is first changed from offset binary to two's complement. If the end-of-conversion flag never comes, the controller gives up after a set bound and raises a timeout pulse.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After `rst_n` is released, `adc_rst_o` stays high for RST_CYC cycles. While `adc_rst_o` is high, `adc_cs_n_o` is always high. In reset and in idle, `result_vld_o` and `timeout_o` are low.
- R2: Each accepted start makes exactly three low pulses on `adc_cs_n_o`. `adc_rc_o` is 0 on the first pulse, equal to the latched mode bit on the second pulse (1 = shutdown, 0 = standby), and 1 on the third pulse.
- R3: `adc_rc_o` is stable for at least SETUP_CYC cycles before every falling edge of `adc_cs_n_o`. It does not change until HOLD_CYC cycles after that falling edge.
- R4: Each low pulse on `adc_cs_n_o` lasts at least CSL_CYC cycles, and each high interval between pulses lasts at least CSH_CYC cycles.
- R5: The second falling edge comes at least ACQ_CYC cycles after the first falling edge.
- R6: The wake-up wait applies when the previous conversion chose shutdown, or when no conversion has run since reset. In that case the second falling edge comes at least WAKE_CYC cycles after the first. Otherwise no wake-up wait is added, so the gap is shorter than WAKE_CYC when WAKE_CYC is the largest limit.
- R7: The third pulse is issued only after `adc_eoc_n_i` has been seen low following the second pulse.
- R8: `adc_data_i` is captured during the third low pulse, at the clock edge that ends the DO_CYC-th full cycle after that pulse's falling edge, and not earlier.
- R9: When the third pulse ends, `result_vld_o` pulses high for exactly one cycle. With OFFSET_BIN = 1, `result_o` is the captured code with bit 15 inverted. With OFFSET_BIN = 0, `result_o` is the captured code unchanged.
- R10: Each new first falling edge comes at least BR_CYC cycles after the rising edge that ended the previous cycle.
- R11: If `adc_eoc_n_i` stays high for EOC_TMO_CYC cycles after the second pulse, `timeout_o` pulses for one cycle. No third pulse and no valid strobe follow, and the controller returns to idle.
- R12: `mode_sd_i` is sampled only when a start is accepted. A start strobe that arrives while `busy_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Strobe that begins one conversion cycle |
| mode_sd_i | input | 1 | Power state after conversion: 1 shutdown, 0 standby |
| adc_eoc_n_i | input | 1 | End-of-conversion flag from the converter, active low |
| adc_data_i | input | DW | Converter data bus |
| adc_cs_n_o | output | 1 | Chip select to the converter, active low |
| adc_rc_o | output | 1 | Read/convert level to the converter |
| adc_rst_o | output | 1 | Reset line to the converter, active high |
| result_o | output | DW | Captured, optionally recoded result |
| result_vld_o | output | 1 | One-cycle strobe marking a new result |
| busy_o | output | 1 | High while a reset or conversion cycle is in progress |
| timeout_o | output | 1 | One-cycle pulse when end of conversion does not arrive |

## Verification
The bench model of the converter drives junk on the data bus until exactly DO_CYC cycles into the third pulse. A controller that samples one cycle early therefore returns a wrong code. The bench measures the acquisition gap both right after a shutdown and right after a standby conversion. A design that skips the wake-up wait fails the shutdown case, and one that always applies it fails the standby case. Random mode changes and extra start strobes are applied after each start to expose a mode bit that is read too late or a start that is not ignored while busy. A converter that never finishes checks that the controller stops after two pulses with a single timeout pulse. Code checks at both ends of the range show whether the sign bit is inverted correctly.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [2:0] {
      ST_RST,
      ST_IDLE,
      ST_SET,
      ST_LOW,
      ST_HIGH,
      ST_ACQ,
      ST_CONV,
      ST_BR
   } seq_state_e;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/adc_seq_acq.sv
module adc_seq_acq #(
   parameter int ACQ_CYC  = 200,
   parameter int WAKE_CYC = 1200000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go_i,
   input  logic wake_i,
   output logic done_o
);
   import adc_seq_pkg::*;

   localparam int NEED_MAX = max2(ACQ_CYC, WAKE_CYC);
   localparam int AW       = $clog2(NEED_MAX + 1);

   logic [AW-1:0] cnt_q;
   logic [AW-1:0] need;

   initial begin : chk_param
      assert (ACQ_CYC >= 1) else $error("ACQ_CYC must be at least 1");
      assert (WAKE_CYC >= 1) else $error("WAKE_CYC must be at least 1");
   end

   assign need   = wake_i ? AW'(NEED_MAX) : AW'(ACQ_CYC);
   assign done_o = (cnt_q >= need);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (go_i) begin
         cnt_q <= '0;
      end else if (cnt_q != AW'(NEED_MAX)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R5: a fresh acquisition window is never already complete
   p_go_restarts_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      go_i |=> !done_o);

endmodule

// File: rtl/adc_seq_fmt.sv
module adc_seq_fmt #(
   parameter int DW         = 16,
   parameter bit OFFSET_BIN = 1'b1
) (
   input  logic [DW-1:0] raw_i,
   output logic [DW-1:0] code_o
);

   initial begin : chk_param
      assert (DW >= 2) else $error("DW must be at least 2");
   end

   generate
      if (OFFSET_BIN) begin : g_offset
         assign code_o = {~raw_i[DW-1], raw_i[DW-2:0]};
      end else begin : g_plain
         assign code_o = raw_i;
      end
   endgenerate

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm #(
   parameter int DW          = 16,
   parameter int RST_CYC     = 4,
   parameter int SETUP_CYC   = 6,
   parameter int HOLD_CYC    = 8,
   parameter int CSL_CYC     = 6,
   parameter int CSH_CYC     = 4,
   parameter int DO_CYC      = 8,
   parameter int BR_CYC      = 8,
   parameter int EOC_TMO_CYC = 600
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          mode_sd_i,
   input  logic          eoc_n_i,
   input  logic [DW-1:0] data_i,
   input  logic          acq_done_i,
   output logic          acq_go_o,
   output logic          wake_o,
   output logic          cs_n_o,
   output logic          rc_o,
   output logic          arst_o,
   output logic [DW-1:0] raw_o,
   output logic          raw_vld_o,
   output logic          busy_o,
   output logic          timeout_o
);
   import adc_seq_pkg::*;

   localparam int LOW_CYC    = max2(CSL_CYC, HOLD_CYC);
   localparam int RD_LOW_CYC = max2(LOW_CYC, DO_CYC + 1);
   localparam int CMAX       = max2(max2(max2(RST_CYC, SETUP_CYC), max2(RD_LOW_CYC, CSH_CYC)),
                                    max2(EOC_TMO_CYC, BR_CYC));
   localparam int CW         = $clog2(CMAX + 1);

   seq_state_e    state_q, state_d;
   logic [CW-1:0] cnt_q, cnt_d, lim;
   logic [1:0]    pidx_q, pidx_d;
   logic          sd_q, sd_d;
   logic          prev_sd_q;
   logic          rc_q, cs_n_q, arst_q, vld_q, tmo_q;
   logic [DW-1:0] raw_q;
   logic          last, capture, rd_done, tmo_hit, lvl;

   initial begin : chk_param
      assert (RST_CYC >= 1 && SETUP_CYC >= 1 && HOLD_CYC >= 1) else $error("cycle limits must be positive");
      assert (CSL_CYC >= 1 && CSH_CYC >= 1 && BR_CYC >= 1) else $error("cycle limits must be positive");
      assert (DO_CYC >= 1 && EOC_TMO_CYC >= 1) else $error("cycle limits must be positive");
   end

   // length of the phase the sequencer is in
   always_comb begin
      unique case (state_q)
         ST_RST:  lim = CW'(RST_CYC);
         ST_SET:  lim = CW'(SETUP_CYC);
         ST_LOW:  lim = (pidx_q == 2'd2) ? CW'(RD_LOW_CYC) : CW'(LOW_CYC);
         ST_HIGH: lim = CW'(CSH_CYC);
         ST_CONV: lim = CW'(EOC_TMO_CYC);
         ST_BR:   lim = CW'(BR_CYC);
         default: lim = '0;
      endcase
   end

   assign last    = (cnt_q == lim - 1'b1);
   assign capture = (state_q == ST_LOW) && (pidx_q == 2'd2) && (cnt_q == CW'(DO_CYC));
   assign rd_done = (state_q == ST_HIGH) && last && (pidx_q == 2'd2);
   assign tmo_hit = (state_q == ST_CONV) && eoc_n_i && last;

   always_comb begin
      state_d = state_q;
      pidx_d  = pidx_q;
      sd_d    = sd_q;
      unique case (state_q)
         ST_RST:  if (last) state_d = ST_BR;
         ST_IDLE: if (start_i) begin
            state_d = ST_SET;
            pidx_d  = 2'd0;
            sd_d    = mode_sd_i;
         end
         ST_SET:  if (last) state_d = ST_LOW;
         ST_LOW:  if (last) state_d = ST_HIGH;
         ST_HIGH: if (last) begin
            unique case (pidx_q)
               2'd0:    state_d = ST_ACQ;
               2'd1:    state_d = ST_CONV;
               default: state_d = ST_BR;
            endcase
         end
         ST_ACQ:  if (acq_done_i) begin
            state_d = ST_SET;
            pidx_d  = 2'd1;
         end
         ST_CONV: if (!eoc_n_i) begin
            state_d = ST_SET;
            pidx_d  = 2'd2;
         end else if (last) begin
            state_d = ST_BR;
         end
         ST_BR:   if (last) state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
      cnt_d = (state_d != state_q) ? '0 : cnt_q + 1'b1;
   end

   // read/convert level for the pulse about to be set up
   assign lvl = (pidx_d == 2'd0) ? 1'b0 : (pidx_d == 2'd1) ? sd_q : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_RST;
         cnt_q     <= '0;
         pidx_q    <= 2'd0;
         sd_q      <= 1'b0;
         prev_sd_q <= 1'b1;
         rc_q      <= 1'b1;
         cs_n_q    <= 1'b1;
         arst_q    <= 1'b1;
         raw_q     <= '0;
         vld_q     <= 1'b0;
         tmo_q     <= 1'b0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         pidx_q  <= pidx_d;
         sd_q    <= sd_d;
         if (state_d == ST_CONV && state_q != ST_CONV) prev_sd_q <= sd_q;
         if (state_d == ST_SET && state_q != ST_SET) rc_q <= lvl;
         cs_n_q  <= (state_d != ST_LOW);
         arst_q  <= (state_d == ST_RST);
         if (capture) raw_q <= data_i;
         vld_q   <= rd_done;
         tmo_q   <= tmo_hit;
      end
   end

   assign acq_go_o  = (state_q == ST_SET) && last && (pidx_q == 2'd0);
   assign wake_o    = prev_sd_q;
   assign cs_n_o    = cs_n_q;
   assign rc_o      = rc_q;
   assign arst_o    = arst_q;
   assign raw_o     = raw_q;
   assign raw_vld_o = vld_q;
   assign busy_o    = (state_q != ST_IDLE);
   assign timeout_o = tmo_q;

   // R1: converter reset never overlaps a selected chip
   p_rst_cs_high_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      arst_q |-> cs_n_q);
   // R1: idle keeps the converter deselected and out of reset
   p_idle_quiet_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE) |-> (cs_n_q && !arst_q && !vld_q));
   // R3: read/convert never moves while chip select is low
   p_rc_hold_low_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n_q |-> $stable(rc_q));
   // R7: the read pulse starts only once conversion has ended
   p_read_after_eoc_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cs_n_q) && pidx_q == 2'd2) |-> !eoc_n_i);
   // R9: valid is a single-cycle strobe
   p_vld_single_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      vld_q |=> !vld_q);
   // R11: timeout and result never coincide
   p_tmo_excl_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      tmo_q |-> (!vld_q && cs_n_q));
   // R12: latched mode is frozen while a cycle runs
   p_mode_frozen_r12 : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE) |=> (sd_q == $past(sd_q)));

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
   parameter int DW          = 16,
   parameter bit OFFSET_BIN  = 1'b1,
   parameter int RST_CYC     = 4,
   parameter int SETUP_CYC   = 6,
   parameter int HOLD_CYC    = 8,
   parameter int CSL_CYC     = 6,
   parameter int CSH_CYC     = 4,
   parameter int ACQ_CYC     = 200,
   parameter int WAKE_CYC    = 1200000,
   parameter int DO_CYC      = 8,
   parameter int BR_CYC      = 8,
   parameter int EOC_TMO_CYC = 600
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          mode_sd_i,
   input  logic          adc_eoc_n_i,
   input  logic [DW-1:0] adc_data_i,
   output logic          adc_cs_n_o,
   output logic          adc_rc_o,
   output logic          adc_rst_o,
   output logic [DW-1:0] result_o,
   output logic          result_vld_o,
   output logic          busy_o,
   output logic          timeout_o
);

   logic          acq_go, acq_done, wake;
   logic [DW-1:0] raw;

   adc_seq_fsm #(
      .DW(DW), .RST_CYC(RST_CYC), .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC),
      .CSL_CYC(CSL_CYC), .CSH_CYC(CSH_CYC), .DO_CYC(DO_CYC), .BR_CYC(BR_CYC),
      .EOC_TMO_CYC(EOC_TMO_CYC)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_sd_i(mode_sd_i),
      .eoc_n_i(adc_eoc_n_i), .data_i(adc_data_i), .acq_done_i(acq_done),
      .acq_go_o(acq_go), .wake_o(wake), .cs_n_o(adc_cs_n_o), .rc_o(adc_rc_o),
      .arst_o(adc_rst_o), .raw_o(raw), .raw_vld_o(result_vld_o),
      .busy_o(busy_o), .timeout_o(timeout_o)
   );

   adc_seq_acq #(
      .ACQ_CYC(ACQ_CYC), .WAKE_CYC(WAKE_CYC)
   ) u_acq (
      .clk(clk), .rst_n(rst_n), .go_i(acq_go), .wake_i(wake), .done_o(acq_done)
   );

   adc_seq_fmt #(
      .DW(DW), .OFFSET_BIN(OFFSET_BIN)
   ) u_fmt (
      .raw_i(raw), .code_o(result_o)
   );

endmodule

// File: tb/adc_seq_ctrl_tb_top.sv
module adc_seq_ctrl_tb_top;
   localparam int RST = 3, SETUP = 3, HOLD = 5, CSL = 4, CSH = 3;
   localparam int ACQ = 40, WAKE = 300, DO = 6, BR = 5, TMO = 120;
   localparam int LIMIT = 150000;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst_n = 1'b0, start = 1'b0, mode_sd = 1'b0, eoc_n = 1'b1;
   logic [15:0] data;
   logic        cs_n, rc, arst, vld, busy, tmo;
   logic [15:0] result;

   adc_seq_ctrl #(
      .DW(16), .OFFSET_BIN(1'b1), .RST_CYC(RST), .SETUP_CYC(SETUP), .HOLD_CYC(HOLD),
      .CSL_CYC(CSL), .CSH_CYC(CSH), .ACQ_CYC(ACQ), .WAKE_CYC(WAKE), .DO_CYC(DO),
      .BR_CYC(BR), .EOC_TMO_CYC(TMO)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start), .mode_sd_i(mode_sd),
      .adc_eoc_n_i(eoc_n), .adc_data_i(data), .adc_cs_n_o(cs_n), .adc_rc_o(rc),
      .adc_rst_o(arst), .result_o(result), .result_vld_o(vld), .busy_o(busy),
      .timeout_o(tmo)
   );

   int checks = 0, fails = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_code(input logic [15:0] v);
      return v ^ 16'h8000;
   endfunction

   // converter model
   int          mdl_pidx = 0, low_cnt = 0, conv_cnt = 0, conv_lat = 10;
   bit          conv_run = 0, rd_phase = 0, no_eoc = 0;
   logic        cs_prev_m = 1'b1;
   logic [15:0] cur_val = 16'h0;

   assign data = (rd_phase && low_cnt >= DO) ? cur_val : (16'hA5C3 ^ 16'(low_cnt));

   always @(posedge clk) begin
      cs_prev_m <= cs_n;
      low_cnt   <= cs_n ? 0 : low_cnt + 1;
      if (arst) begin
         mdl_pidx <= 0; eoc_n <= 1'b1; conv_run <= 0; rd_phase <= 0;
      end else begin
         if (cs_prev_m && !cs_n) begin
            if (mdl_pidx == 1) begin conv_run <= 1; conv_cnt <= 0; end
            if (mdl_pidx == 2) rd_phase <= 1;
            mdl_pidx <= (mdl_pidx + 1) % 3;
         end
         if (!cs_prev_m && cs_n && rd_phase) begin
            rd_phase <= 0; eoc_n <= 1'b1;
         end
         if (conv_run) begin
            conv_cnt <= conv_cnt + 1;
            if (conv_cnt + 1 >= conv_lat && !no_eoc) begin
               eoc_n <= 1'b0; conv_run <= 0;
            end
         end
      end
   end

   // pin timing monitor
   logic cs_p = 1'b1, rc_p = 1'b1, vld_p = 1'b0;
   int   since_rc = 1 << 20, since_fall = 1 << 20, since_rise = 1 << 20;
   int   mon_pidx = 0, cyc = 0, fall1_t = 0, falls_total = 0, vld_count = 0;
   bit   wake_next = 1, exp_mode = 0;

   always @(negedge clk) begin
      cyc++;
      if (!rst_n || arst) begin mon_pidx = 0; wake_next = 1; end
      if (arst && !cs_n) chk(0, "R1", "chip select low during converter reset", 0, 1);
      if (rst_n && rc != rc_p) begin
         chk(since_fall >= HOLD, "R3", "hold after fall", since_fall, HOLD);
         since_rc = 0;
      end else since_rc++;
      since_fall++;
      since_rise++;
      if (rst_n && cs_p && !cs_n) begin
         chk(since_rc >= SETUP, "R3", "setup before fall", since_rc, SETUP);
         chk(since_rise >= CSH, "R4", "high width", since_rise, CSH);
         if (mon_pidx == 0) begin
            chk(rc == 1'b0, "R2", "rc on first pulse", rc, 0);
            chk(since_rise >= BR, "R10", "bus release gap", since_rise, BR);
            fall1_t = cyc;
         end else if (mon_pidx == 1) begin
            chk(rc == exp_mode, "R2", "rc on second pulse", rc, exp_mode);
            chk(cyc - fall1_t >= ACQ, "R5", "acquisition gap", cyc - fall1_t, ACQ);
            if (wake_next)
               chk(cyc - fall1_t >= WAKE, "R6", "wake gap", cyc - fall1_t, WAKE);
            else
               chk(cyc - fall1_t < WAKE, "R6", "no wake gap", cyc - fall1_t, WAKE - 1);
            wake_next = exp_mode;
         end else begin
            chk(rc == 1'b1, "R2", "rc on third pulse", rc, 1);
            chk(eoc_n == 1'b0, "R7", "eoc low at read pulse", eoc_n, 0);
         end
         mon_pidx = (mon_pidx + 1) % 3;
         falls_total++;
         since_fall = 0;
      end
      if (rst_n && !cs_p && cs_n) begin
         chk(since_fall >= CSL, "R4", "low width", since_fall, CSL);
         since_rise = 0;
      end
      if (vld) begin
         vld_count++;
         chk(!vld_p, "R9", "valid longer than one cycle", 1, 0);
         chk(result == exp_code(cur_val), "R8", "captured code", result, exp_code(cur_val));
         chk(mon_pidx == 0, "R2", "pulses before valid", mon_pidx, 0);
      end
      cs_p = cs_n; rc_p = rc; vld_p = vld;
   end

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   always @(posedge clk) if (cyc > LIMIT) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, LIMIT);
      summary();
   end

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(cs_n == 1'b1, "R1", "cs in reset", cs_n, 1);
      chk(arst == 1'b1, "R1", "converter reset in reset", arst, 1);
      chk(!vld && !tmo, "R1", "strobes in reset", vld | tmo, 0);
      rst_n = 1'b1;
      while (busy) @(negedge clk);
      chk(arst == 1'b0 && cs_n == 1'b1, "R1", "idle after reset", {arst, cs_n}, 1);
   endtask

   task automatic convert(input bit mode, input int lat, input logic [15:0] val);
      int f0, v0;
      while (busy) @(negedge clk);
      cur_val = val; conv_lat = lat; exp_mode = mode; mode_sd = mode;
      f0 = falls_total; v0 = vld_count;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      mode_sd = ~mode;                      // R12: late mode change must not matter
      @(negedge clk);
      start = 1'b1;                         // R12: start while busy is ignored
      @(negedge clk);
      start = 1'b0;
      mode_sd = 1'($urandom);
      while (busy) @(negedge clk);
      repeat (4) @(negedge clk);
      chk(falls_total - f0 == 3, "R12", "pulses per start", falls_total - f0, 3);
      chk(vld_count - v0 == 1, "R9", "valid strobes per start", vld_count - v0, 1);
      chk(!busy, "R12", "no extra cycle", busy, 0);
   endtask

   task automatic timeout_case();
      int f0, v0, tc;
      while (busy) @(negedge clk);
      no_eoc = 1; exp_mode = 1'b0; mode_sd = 1'b0;
      f0 = falls_total; v0 = vld_count; tc = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (busy) begin
         if (tmo) tc++;
         @(negedge clk);
      end
      repeat (4) @(negedge clk);
      chk(tc == 1, "R11", "timeout pulses", tc, 1);
      chk(falls_total - f0 == 2, "R11", "pulses before timeout", falls_total - f0, 2);
      chk(vld_count == v0, "R11", "no valid on timeout", vld_count - v0, 0);
      no_eoc = 0;
   endtask

   initial begin
      void'($urandom(32'd20240611));
      do_reset();
      convert(1'b0, 5, 16'h0000);          // wake after reset, lowest code
      convert(1'b0, 1, 16'hFFFF);          // standby, no wake, fastest eoc
      convert(1'b1, 40, 16'h8000);         // selects shutdown
      convert(1'b0, 80, 16'h7FFF);         // wakes from shutdown
      for (int i = 0; i < 20; i++)
         convert(1'($urandom), 1 + ($urandom % 90), 16'($urandom));
      timeout_case();
      do_reset();
      convert(1'b1, 12, 16'h1234);         // wake again after reset
      summary();
   end

endmodule